// File: doc/BRIEF.md
# Looping Output Signal Pattern Sequencer

This block drives one 1-bit output from a small stored program that runs synchronously to the design clock. Each program word holds an opcode and a 16-bit operand. There are four opcodes. SET drives the output level. WAIT holds the output for a number of clocks. RESTART jumps back to slot 0. STOP freezes the sequencer. With these, one program can produce an endless periodic waveform or a single one-shot pulse train.

A host port writes program words one slot at a time. The `rearm` input returns the sequencer to slot 0 with the output low. While it is held high, the sequencer is idle, so a program can be loaded safely. A rearm keeps the stored program, while a reset also clears it. Designs with several outputs use one instance per output.

A RESTART costs no clock and neither does a WAIT of zero, so a loop closes with no gap. SET and each counted WAIT clock are the only things that take time.

Top module: `pattern_seq`

## Requirements
- R1: A program word is 18 bits wide. Bits [17:16] hold the opcode: 00 STOP, 01 SET, 10 WAIT, 11 RESTART. Bits [15:0] hold the operand. A clock with `prog_we` high stores `prog_data` in slot `prog_addr`. Reset fills every slot with zero, which decodes as STOP.
- R2: A SET executed on a clock edge drives `wave_o` to operand bit 0 right after that edge. The SET occupies exactly one clock.
- R3: A WAIT with operand n ≥ 1 holds `wave_o` unchanged for n clocks, after which the next slot runs.
- R4: A WAIT with operand 0 takes no clock: the next slot runs on the same edge.
- R5: RESTART jumps to slot 0 and runs that slot on the same edge. The program SET 0, WAIT 4, SET 1, WAIT 6, RESTART therefore gives a wave that is 5 clocks low and 7 clocks high, repeating with a period of 12.
- R6: STOP halts the sequencer, and `wave_o` keeps its level until reset or rearm.
- R7: Advancing past the last slot (DEPTH-1) behaves as STOP. Execution never wraps to slot 0.
- R8: While `rst` or `rearm` is high, `wave_o` is 0 and the program counter is 0. Slot 0 runs on the first clock edge after both are low. A rearm leaves the stored program intact.
- R9: If the sequencer reaches a chain made only of RESTARTs and zero WAITs, and so can never reach an instruction that takes time, it halts and holds `wave_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset; clears the program and the sequencer |
| rearm | input | 1 | Synchronous restart of the sequencer from slot 0; the program is kept |
| prog_we | input | 1 | Program word write strobe |
| prog_addr | input | $clog2(DEPTH) | Slot written by the host |
| prog_data | input | 18 | Program word (opcode in [17:16], operand in [15:0]) |
| wave_o | output | 1 | Generated waveform |

## Verification
Two things share one clock edge here. The first pair is a RESTART and the execution of slot 0. The second is a chain of zero WAITs and the SET that follows them. Both are provoked by looping programs and by programs full of zero waits. A scoreboard judges them by comparing every clock of the output against a hand-derived expected stream. An idle cycle inserted at either point shifts every following level and fails the comparison. The stream for the reference loop must show exactly 5 low and 7 high clocks.

// File: rtl/patseq_pkg.sv
package patseq_pkg;

    localparam int OPND_W = 16;

    typedef enum logic [1:0] {
        OP_STOP = 2'b00,
        OP_SET  = 2'b01,
        OP_WAIT = 2'b10,
        OP_LOOP = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [OPND_W-1:0] arg;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    // An instruction that takes no clock: the walk passes straight over it.
    function automatic logic is_pass(instr_t i);
        return (i.op == OP_LOOP) || ((i.op == OP_WAIT) && (i.arg == '0));
    endfunction

endpackage

// File: rtl/patseq_progmem.sv
module patseq_progmem
    import patseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  instr_t                 wdata,
    output instr_t [DEPTH-1:0]     slots_o
);

    instr_t [DEPTH-1:0] mem_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= '0;
                end else if (we && (waddr == AW'(g))) begin
                    mem_q[g] <= wdata;
                end
            end
        end
    endgenerate

    assign slots_o = mem_q;

    // R1: a host write is visible in its slot on the next clock
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        (we && (32'(waddr) < DEPTH)) |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/patseq_resolve.sv
module patseq_resolve
    import patseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PCW   = AW + 1
) (
    input  instr_t [DEPTH-1:0] slots_i,
    input  logic [PCW-1:0]     pc_i,
    output logic               found_o,
    output logic [PCW-1:0]     pc_o,
    output instr_t             ins_o
);

    // DEPTH+1 steps reach every distinct slot plus the past-the-end point.
    localparam int STEPS = DEPTH + 1;

    always_comb begin
        logic [PCW-1:0] walk;
        logic           hit;
        logic [PCW-1:0] hpc;
        instr_t         hins;
        instr_t         f;
        walk = pc_i;
        hit  = 1'b0;
        hpc  = '0;
        hins = '0;
        for (int k = 0; k < STEPS; k++) begin
            // Past the last slot reads as STOP (all zero word).
            f = (walk < PCW'(DEPTH)) ? slots_i[walk[AW-1:0]] : '0;
            if (!hit && !is_pass(f)) begin
                hit  = 1'b1;
                hpc  = walk;
                hins = f;
            end
            walk = (f.op == OP_LOOP) ? '0 : walk + PCW'(1);
        end
        found_o = hit;
        pc_o    = hpc;
        ins_o   = hins;
    end

endmodule

// File: rtl/patseq_core.sv
module patseq_core
    import patseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PCW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rearm,
    input  logic           found_i,
    input  logic [PCW-1:0] r_pc_i,
    input  instr_t         r_ins_i,
    output logic [PCW-1:0] pc_o,
    output logic           wave_o
);

    logic [PCW-1:0]    pc_q;
    logic [OPND_W-1:0] wcnt_q;
    logic              halt_q;
    logic              wave_q;
    op_e               exec_op;

    // An unresolvable chain is executed as a STOP.
    assign exec_op = found_i ? r_ins_i.op : OP_STOP;

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            pc_q   <= '0;
            wcnt_q <= '0;
            halt_q <= 1'b0;
            wave_q <= 1'b0;
        end else if (halt_q) begin
            pc_q <= pc_q;
        end else if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - OPND_W'(1);
        end else begin
            case (exec_op)
                OP_SET: begin
                    wave_q <= r_ins_i.arg[0];
                    pc_q   <= r_pc_i + PCW'(1);
                end
                OP_WAIT: begin
                    wcnt_q <= r_ins_i.arg - OPND_W'(1);
                    pc_q   <= r_pc_i + PCW'(1);
                end
                default: begin
                    halt_q <= 1'b1;
                    pc_q   <= found_i ? r_pc_i : pc_q;
                end
            endcase
        end
    end

    assign pc_o   = pc_q;
    assign wave_o = wave_q;

    // R3: clocks spent counting down never move the output
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst || rearm)
        (wcnt_q != '0) |=> $stable(wave_q));

    // R6: once halted, stay halted with a frozen level
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst || rearm)
        halt_q |=> ($stable(wave_q) && halt_q));

    // R2: an executed SET lands its operand bit on the output
    p_set_follows_r2: assert property (@(posedge clk) disable iff (rst || rearm)
        (!halt_q && (wcnt_q == '0) && found_i && (r_ins_i.op == OP_SET))
        |=> (wave_q == $past(r_ins_i.arg[0])));

    // R8: reset leaves the output low, the counter at slot 0, not halted
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> ((wave_q == 1'b0) && (pc_q == '0) && !halt_q));

    // R7: the program counter never goes beyond the past-the-end point
    p_pc_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pc_q <= PCW'(DEPTH));

endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
    import patseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PCW  = AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rearm,
    input  logic               prog_we,
    input  logic [AW-1:0]      prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    output logic               wave_o
);

    instr_t [DEPTH-1:0] slots;
    instr_t             wword;
    logic [PCW-1:0]     pc;
    logic               found;
    logic [PCW-1:0]     r_pc;
    instr_t             r_ins;

    assign wword = instr_t'(prog_data);

    patseq_progmem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (prog_we),
        .waddr   (prog_addr),
        .wdata   (wword),
        .slots_o (slots)
    );

    patseq_resolve #(.DEPTH(DEPTH), .AW(AW), .PCW(PCW)) u_res (
        .slots_i (slots),
        .pc_i    (pc),
        .found_o (found),
        .pc_o    (r_pc),
        .ins_o   (r_ins)
    );

    patseq_core #(.DEPTH(DEPTH), .PCW(PCW)) u_core (
        .clk     (clk),
        .rst     (rst),
        .rearm   (rearm),
        .found_i (found),
        .r_pc_i  (r_pc),
        .r_ins_i (r_ins),
        .pc_o    (pc),
        .wave_o  (wave_o)
    );

endmodule

// File: tb/pattern_seq_tb.sv
`timescale 1ns/1ps
module pattern_seq_tb;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rearm = 1'b1;
    logic          prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [17:0]   prog_data = '0;
    logic          wave_o;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;
    exp_t exq[$];
    bit   started = 1'b0;

    always #2 clk = ~clk;

    pattern_seq #(.DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .rearm     (rearm),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .wave_o    (wave_o)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wave_o=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Monitor: one expected level per clock, starting one clock after release.
    always @(negedge clk) begin
        if (rearm || rst) begin
            started <= 1'b0;
        end else if (!started) begin
            started <= 1'b1;
        end else if (exq.size() != 0) begin
            exp_t e;
            e = exq.pop_front();
            chk(e.tag, wave_o, e.v);
        end
    end

    task automatic push_run(logic v, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = v;
            e.tag = tag;
            exq.push_back(e);
        end
    endtask

    task automatic load(int a, logic [1:0] op, logic [15:0] arg);
        @(posedge clk); #1;
        prog_we   = 1'b1;
        prog_addr = AW'(a);
        prog_data = {op, arg};
        @(posedge clk); #1;
        prog_we   = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst   = 1'b1;
        rearm = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R8 reset level", wave_o, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic run();
        @(posedge clk); #1;
        rearm = 1'b0;
        while (exq.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        rearm = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        // R5 / R2 / R3: reference square-wave loop with gapless restart
        do_reset();
        load(0, 2'b01, 16'd0);
        load(1, 2'b10, 16'd4);
        load(2, 2'b01, 16'd1);
        load(3, 2'b10, 16'd6);
        load(4, 2'b11, 16'd0);
        push_run(1'b0, 5, "R5 low phase");
        push_run(1'b1, 7, "R5 high phase");
        push_run(1'b0, 5, "R5 low phase 2");
        push_run(1'b1, 7, "R5 high phase 2");
        run();

        // R8: rearm restarts from slot 0 with the program kept
        push_run(1'b0, 5, "R8 rearm low");
        push_run(1'b1, 2, "R8 rearm high");
        run();

        // R4 / R6: zero waits take no clock, stop holds the level
        do_reset();
        load(0, 2'b01, 16'd1);
        load(1, 2'b10, 16'd0);
        load(2, 2'b01, 16'd0);
        load(3, 2'b10, 16'd0);
        load(4, 2'b10, 16'd0);
        load(5, 2'b01, 16'd1);
        load(6, 2'b00, 16'd0);
        push_run(1'b1, 1, "R4 set1");
        push_run(1'b0, 1, "R4 skip to set0");
        push_run(1'b1, 1, "R4 skip two to set1");
        push_run(1'b1, 10, "R6 stop holds");
        run();

        // R3: counted wait of 3
        do_reset();
        load(0, 2'b01, 16'd1);
        load(1, 2'b10, 16'd3);
        load(2, 2'b01, 16'd0);
        load(3, 2'b00, 16'd0);
        push_run(1'b1, 4, "R3 set plus wait");
        push_run(1'b0, 4, "R3 after wait");
        run();

        // R7: running past the last slot stops, no wrap
        do_reset();
        load(0, 2'b01, 16'd1);
        for (int s = 1; s < DEPTH - 2; s++) load(s, 2'b10, 16'd0);
        load(DEPTH - 2, 2'b01, 16'd0);
        load(DEPTH - 1, 2'b01, 16'd1);
        push_run(1'b1, 1, "R7 slot0");
        push_run(1'b0, 1, "R7 second last");
        push_run(1'b1, 6, "R7 past end holds");
        run();

        // R9: chain of only zero waits and restarts halts
        do_reset();
        load(0, 2'b10, 16'd0);
        load(1, 2'b11, 16'd0);
        push_run(1'b0, 6, "R9 stuck chain");
        run();

        // R1 / R2: operand bit 0 drives; reset wipes the program to STOP
        do_reset();
        load(0, 2'b01, 16'hFFFF);
        load(1, 2'b00, 16'd0);
        push_run(1'b1, 4, "R2 set operand bit0");
        run();
        do_reset();
        push_run(1'b0, 4, "R1 cleared program");
        run();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule